// File: doc/BRIEF.md
# Configurable Control-Pin Function Mapper

This block sits between four general-purpose control inputs of a clock generator and the functions they steer. A static configuration word gives each input one job. It can be the output-enable level, the spread-modulation enable, the selector between two programmed frequency sets, or an active-low power-down. The two upper inputs can also be handed over to act as clock outputs, and then they carry no control function. The block synchronizes the input levels, decodes them through the configuration, and drives the decoded control levels, one output-enable per clock lane, and a low-power request.

Some configurations are illegal: a function assigned twice, power-down on an upper input, clock use of a lower input, or an unknown code. Any of these raises an error flag and forces every function to its inactive default. A lane is switched on or off only on a cycle where the sampled level of the output clock is low, so no clipped pulse reaches a pin.

Top module: `ctlpin_mapper`

## Requirements
- R1: Input k is configured by bits [3k+2:3k] of `cfg_i` with codes 0 = output enable, 1 = spread enable, 2 = frequency select, 3 = power-down (active low), 4 = clock use. A legal control input drives its function with its synchronized level.
- R2: A function assigned to no input takes its default: output enable 1, power-down 1 (not asserted), spread enable 1, frequency select 0.
- R3: Code 3 (power-down) is legal only on inputs 0 and 1. On input 2 or 3 it raises `cfg_err_o`.
- R4: Code 4 (clock use) on input 0 or 1, or any code 5 to 7 on any input, raises `cfg_err_o`.
- R5: Codes 0 to 3 given to more than one input raise `cfg_err_o`. Code 4 on both inputs 2 and 3 is legal.
- R6: While `cfg_err_o` is 1, the four control outputs hold their defaults and lanes 4 and 5 stay off.
- R7: Lanes 0 to 3 are enabled together. Lane 4 (input 2) and lane 5 (input 3) are enabled only when that input has code 4.
- R8: Lanes are on only when output enable is 1 and power-down is not asserted. `lp_req_o` is 1 exactly while the decoded power-down is asserted (level 0).
- R9: A change on `pin_i` reaches the control outputs on the third rising edge after it is applied, and not before. A change on `cfg_i` reaches them on the first edge.
- R10: `lane_oe_o` updates only on an edge where `clk_level_i` is 0. While it is 1, the lanes hold their state.
- R11: During reset the block drives `lane_oe_o` = 0, `cfg_err_o` = 0, `lp_req_o` = 0 and the control defaults of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw control input levels |
| cfg_i | input | 12 | Per-input function codes, 3 bits each |
| clk_level_i | input | 1 | Sampled level of the output clock; 0 allows lane changes |
| oe_o | output | 1 | Decoded output enable |
| sson_o | output | 1 | Decoded spread enable |
| clksel_o | output | 1 | Decoded frequency-set select |
| pd_n_o | output | 1 | Decoded power-down, active low |
| lp_req_o | output | 1 | Low-power request |
| lane_oe_o | output | 6 | Per-lane output enable (0 = high impedance) |
| cfg_err_o | output | 1 | Illegal configuration flag |

## Verification
The bench tries every configuration built from legal codes 0 to 4 on all four inputs against all sixteen input level patterns. This separates correct routing from swapped inputs, missing defaults and missed duplicates. Codes 5 to 7 are then placed on each input in turn, which shows the error fallback works on every input. Directed cases step one input and sample two and three edges later to fix the latency. They also hold the clock level high across an enable change, which shows the decoded level moves while the lanes stay frozen.

// File: rtl/ctlmap_pkg.sv
package ctlmap_pkg;
    localparam int CP_PINS    = 4;
    localparam int CP_FW      = 3;
    localparam int CP_PD_PINS = 2;                       // inputs below this index may carry power-down
    localparam int CP_MU      = CP_PINS - CP_PD_PINS;    // inputs that can become clock lanes
    localparam int CP_CFG_W   = CP_PINS * CP_FW;

    typedef enum logic [CP_FW-1:0] {
        FN_OE   = 3'd0,
        FN_SSON = 3'd1,
        FN_FSEL = 3'd2,
        FN_PWDN = 3'd3,
        FN_CLK  = 3'd4
    } fn_e;

    typedef struct packed {
        logic oe;
        logic sson;
        logic fsel;
        logic pd_n;
        logic err;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '{oe: 1'b1, sson: 1'b1, fsel: 1'b0, pd_n: 1'b1, err: 1'b0};
endpackage

// File: rtl/ctlmap_sync.sv
module ctlmap_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) pipe_q <= '1;
        else          pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ctlmap_decode.sv
module ctlmap_decode
    import ctlmap_pkg::*;
(
    input  logic [CP_CFG_W-1:0] cfg_i,
    input  logic [CP_PINS-1:0]  lvl_i,
    output ctl_t                ctl_o,
    output logic [CP_MU-1:0]    clk_mu_o
);
    always_comb begin
        ctl_t                raw;
        logic                bad;
        logic [3:0]          used;
        logic [CP_FW-1:0]    code;
        logic [CP_MU-1:0]    mu;

        raw  = CTL_DEFAULT;
        bad  = 1'b0;
        used = '0;
        for (int p = 0; p < CP_PINS; p++) begin
            code = cfg_i[p*CP_FW +: CP_FW];
            case (code)
                FN_OE:   begin bad = bad | used[0]; used[0] = 1'b1; raw.oe   = lvl_i[p]; end
                FN_SSON: begin bad = bad | used[1]; used[1] = 1'b1; raw.sson = lvl_i[p]; end
                FN_FSEL: begin bad = bad | used[2]; used[2] = 1'b1; raw.fsel = lvl_i[p]; end
                FN_PWDN: begin
                    bad     = bad | used[3] | (p >= CP_PD_PINS);
                    used[3] = 1'b1;
                    raw.pd_n = lvl_i[p];
                end
                FN_CLK:  bad = bad | (p < CP_PD_PINS);
                default: bad = 1'b1;
            endcase
        end
        for (int m = 0; m < CP_MU; m++) begin
            mu[m] = (cfg_i[(m+CP_PD_PINS)*CP_FW +: CP_FW] == FN_CLK);
        end

        if (bad) begin
            ctl_o     = CTL_DEFAULT;
            ctl_o.err = 1'b1;
            clk_mu_o  = '0;
        end else begin
            ctl_o    = raw;
            clk_mu_o = mu;
        end
    end
endmodule

// File: rtl/ctlpin_mapper.sv
module ctlpin_mapper
    import ctlmap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N_DED_LANES = 4,
    localparam int N_LANES    = N_DED_LANES + CP_MU
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic [CP_PINS-1:0]  pin_i,
    input  logic [CP_CFG_W-1:0] cfg_i,
    input  logic                clk_level_i,
    output logic                oe_o,
    output logic                sson_o,
    output logic                clksel_o,
    output logic                pd_n_o,
    output logic                lp_req_o,
    output logic [N_LANES-1:0]  lane_oe_o,
    output logic                cfg_err_o
);
    typedef struct packed {
        ctl_t               ctl;
        logic               lp;
        logic [N_LANES-1:0] lanes;
    } state_t;

    logic [CP_PINS-1:0] lvl_sync;
    ctl_t               ctl_dec;
    logic [CP_MU-1:0]   clk_mu;
    logic               want_run;
    state_t             st_d, st_q;

    ctlmap_sync #(.W(CP_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (pin_i),
        .q_o     (lvl_sync)
    );

    ctlmap_decode u_dec (
        .cfg_i    (cfg_i),
        .lvl_i    (lvl_sync),
        .ctl_o    (ctl_dec),
        .clk_mu_o (clk_mu)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ctl = ctl_dec;
        st_d.lp  = ~ctl_dec.pd_n;
        want_run = ctl_dec.oe & ctl_dec.pd_n;
        // lanes move only while the output clock sits low
        if (!clk_level_i) begin
            st_d.lanes = want_run ? {clk_mu, {N_DED_LANES{1'b1}}} : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.ctl   <= CTL_DEFAULT;
            st_q.lp    <= 1'b0;
            st_q.lanes <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o      = st_q.ctl.oe;
    assign sson_o    = st_q.ctl.sson;
    assign clksel_o  = st_q.ctl.fsel;
    assign pd_n_o    = st_q.ctl.pd_n;
    assign cfg_err_o = st_q.ctl.err;
    assign lp_req_o  = st_q.lp;
    assign lane_oe_o = st_q.lanes;
endmodule

// File: rtl/ctlpin_mapper_chk.sv
module ctlpin_mapper_chk
    import ctlmap_pkg::*;
#(
    parameter int N_DED = 4,
    parameter int N_LN  = 6
) (
    input logic                clk_i,
    input logic                rst_n_i,
    input logic [CP_CFG_W-1:0] cfg_i,
    input logic                clk_level_i,
    input logic                oe_o,
    input logic                sson_o,
    input logic                clksel_o,
    input logic                pd_n_o,
    input logic [N_LN-1:0]     lane_oe_o,
    input logic                cfg_err_o
);
    AST_LANE_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(lane_oe_o) |-> !$past(clk_level_i)); // R10

    AST_DED_LANES_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (lane_oe_o[N_DED-1:0] == '0) || (lane_oe_o[N_DED-1:0] == '1)); // R7

    generate
        for (genvar m = 0; m < CP_MU; m++) begin : g_mu
            AST_MU_LANE_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                $rose(lane_oe_o[N_DED+m]) |-> $past(cfg_i[(m+CP_PD_PINS)*CP_FW +: CP_FW]) == FN_CLK); // R7
        end
    endgenerate

    AST_ERR_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cfg_err_o |-> (oe_o && pd_n_o && sson_o && !clksel_o)); // R6

    AST_PD_FROM_LOW_PIN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !pd_n_o |-> ($past(cfg_i[0 +: CP_FW]) == FN_PWDN) || ($past(cfg_i[CP_FW +: CP_FW]) == FN_PWDN)); // R3

    AST_PD_HIGH_PIN_ERR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $past(rst_n_i) && (($past(cfg_i[2*CP_FW +: CP_FW]) == FN_PWDN) ||
                           ($past(cfg_i[3*CP_FW +: CP_FW]) == FN_PWDN)) |-> cfg_err_o); // R3
endmodule

bind ctlpin_mapper ctlpin_mapper_chk #(.N_DED(N_DED_LANES), .N_LN(N_LANES)) u_chk (.*);

// File: tb/sim_ctlpin_mapper.sv
`timescale 1ns/1ps
module sim_ctlpin_mapper;
    logic        clk_i = 1'b0;
    logic        rst_n_i = 1'b0;
    logic [3:0]  pin_i = 4'hF;
    logic [11:0] cfg_i = 12'h0;
    logic        clk_level_i = 1'b0;
    logic        oe_o, sson_o, clksel_o, pd_n_o, lp_req_o, cfg_err_o;
    logic [5:0]  lane_oe_o;

    int checks = 0;
    int errors = 0;

    always #10 clk_i = ~clk_i;

    ctlpin_mapper u0 (.*);

    function automatic logic [11:0] pack_act();
        return {cfg_err_o, lp_req_o, oe_o, pd_n_o, sson_o, clksel_o, lane_oe_o};
    endfunction

    // expected {err, lp, oe, pd_n, sson, fsel, lanes[5:0]}
    function automatic logic [11:0] model(input logic [11:0] cfg, input logic [3:0] pins);
        logic oe, pd, ss, fs, err, run;
        logic [1:0] mu;
        logic [5:0] lanes;
        int cnt [4];
        int code;
        oe = 1; pd = 1; ss = 1; fs = 0; err = 0; mu = 0;
        for (int f = 0; f < 4; f++) cnt[f] = 0;
        for (int k = 0; k < 4; k++) begin
            code = int'(cfg[3*k +: 3]);
            if (code > 4) err = 1;
            else if (code == 4) begin
                if (k < 2) err = 1; else mu[k-2] = 1;
            end else begin
                cnt[code]++;
                if (code == 3 && k >= 2) err = 1;
                case (code)
                    0: oe = pins[k];
                    1: ss = pins[k];
                    2: fs = pins[k];
                    default: pd = pins[k];
                endcase
            end
        end
        for (int f = 0; f < 4; f++) if (cnt[f] > 1) err = 1;
        if (err) begin oe = 1; pd = 1; ss = 1; fs = 0; mu = 0; end
        run   = oe & pd;
        lanes = run ? {mu, 4'hF} : 6'h0;
        return {err, ~pd, oe, pd, ss, fs, lanes};
    endfunction

    function automatic logic [11:0] mk(input int c0, input int c1, input int c2, input int c3);
        return {3'(c3), 3'(c2), 3'(c1), 3'(c0)};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic apply(input logic [11:0] cfg, input logic [3:0] pins);
        cfg_i = cfg;
        pin_i = pins;
        edges(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] cfg, e;
        cfg_i = mk(3, 0, 1, 2);
        edges(3);
        check("R11 reset state", pack_act(), {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h00});
        rst_n_i = 1'b1;

        // full sweep of legal codes against every pin pattern
        for (int c = 0; c < 625; c++) begin
            cfg = mk(c % 5, (c / 5) % 5, (c / 25) % 5, (c / 125) % 5);
            for (int p = 0; p < 16; p++) begin
                apply(cfg, 4'(p));
                e = model(cfg, 4'(p));
                check(e[11] ? "R6 fallback sweep" : "R1 decode sweep", pack_act(), e);
            end
        end

        // unknown codes on each input
        for (int k = 0; k < 4; k++) begin
            for (int bad = 5; bad < 8; bad++) begin
                cfg = mk(3, 0, 1, 2);
                cfg[3*k +: 3] = 3'(bad);
                apply(cfg, 4'hA);
                check("R4 unknown code", pack_act(), model(cfg, 4'hA));
                check("R4 unknown code flag", {11'h0, cfg_err_o}, 12'h1);
            end
        end

        // R2: only enable and spread assigned, both upper inputs as clocks
        apply(mk(0, 1, 4, 4), 4'hF);
        check("R2 defaults", pack_act(), {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h3F});
        check("R5 two clock inputs legal", {11'h0, cfg_err_o}, 12'h0);

        apply(mk(0, 1, 3, 2), 4'hF);
        check("R3 power-down on input 2", pack_act(), {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h0F});

        apply(mk(4, 0, 1, 2), 4'hF);
        check("R4 clock on input 0", {11'h0, cfg_err_o}, 12'h1);

        apply(mk(0, 0, 4, 4), 4'h0);
        check("R5 duplicate enable", pack_act(), {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h0F});

        apply(mk(3, 0, 4, 4), 4'b0010);
        check("R8 power-down overrides enable", pack_act(), {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'h00});

        apply(mk(0, 1, 4, 2), 4'hF);
        check("R7 lane 4 only", {6'h0, lane_oe_o}, 12'h01F);

        // R9 latency
        apply(mk(0, 1, 2, 4), 4'hF);
        pin_i = 4'hE;
        edges(2);
        check("R9 not before third edge", {11'h0, oe_o}, 12'h1);
        edges(1);
        check("R9 at third edge", {11'h0, oe_o}, 12'h0);

        // R10 lane gating on clock level
        apply(mk(0, 1, 2, 4), 4'hF);
        check("R10 lanes on", {6'h0, lane_oe_o}, 12'h02F);
        clk_level_i = 1'b1;
        pin_i = 4'hE;
        edges(5);
        check("R10 level moved", {11'h0, oe_o}, 12'h0);
        check("R10 lanes frozen", {6'h0, lane_oe_o}, 12'h02F);
        clk_level_i = 1'b0;
        edges(1);
        check("R10 lanes stop at low level", {6'h0, lane_oe_o}, 12'h000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule